// File: doc/BRIEF.md
# Serial Port FIFO and Interrupt Front End

This block sits between a byte-wide register bus and the byte-level side of a serial engine. It buffers received bytes in one FIFO and bytes waiting to be sent in another. Both FIFOs are reached through a single data address: a bus read takes the oldest received byte, and a bus write queues a byte for sending. The serial engine pushes received bytes in on one side and pops bytes to send from the other.

Software watches the fill state through a status register. A single interrupt line combines two sources, one for the transmit side and one for the receive side. Each source has a latched flag. Hardware sets a flag while its condition holds. Software can clear a flag, force it on, and mask it, each through its own register.

The receive condition only fires above a programmable level, and that level can never be set below half of the FIFO. A driver that polls can still catch a trickle of data by forcing the receive flag. A flush command empties both FIFOs and drops all flags. It keeps the configuration and the interrupt mask.

Top module: `serq_front`

## Requirements
- R1: After reset, a read of the status register (address 2) returns 0x84, the config register (address 3) and the enable register (address 6) read 0, `irq`, `tx_valid` and `rx_full` are low, and `bus_rdata` is 0.
- R2: A bus write to address 1 queues the byte in the transmit FIFO. With transmit FIFO mode on, up to 16 bytes are held. `tx_byte` shows the oldest byte while `tx_valid` is high, and a `tx_pop` pulse removes that byte.
- R3: A bus write to address 1 while the transmit FIFO is full is dropped. This also applies when a `tx_pop` occurs in the same cycle. Later pops never return the dropped byte.
- R4: A bus read of address 1 removes the oldest received byte. `bus_rdata` carries the result of any read from the cycle after the read strobe and holds it until the next read. Bytes come out in arrival order.
- R5: A read of address 1 with the receive FIFO empty returns the last byte removed and leaves the FIFO unchanged. A byte pushed afterwards is the next one read.
- R6: The status register holds four flags, and all its other bits read 0:
  - bit 2: the receive FIFO is empty.
  - bit 3: the receive condition of R7 holds.
  - bit 4: the transmit FIFO is full.
  - bit 7: the transmit FIFO is low. In FIFO mode this means it holds fewer than 8 bytes. In single mode it means it is empty.
- R7: Config bits [2:0] hold a code c. In receive FIFO mode, the receive condition holds when the fill count is greater than 15 − c, so c = 7 fires above 8 bytes. In single mode it holds when the FIFO is non-empty.
- R8: Config bit 3 turns on receive FIFO mode and bit 7 turns on transmit FIFO mode. A FIFO whose mode bit is clear holds only one byte, and `rx_full` reports receive full. Only bits 7, 3 and 2:0 of the config register are stored, so writing 0xFF reads back 0x8F.
- R9: Flag bit 0 (transmit) is set by hardware while the transmit FIFO is low. Flag bit 1 (receive) is set by hardware while the receive condition holds. Both are read at address 7. A set flag stays set after its condition ends, until a 1 is written to its bit at address 4.
- R10: Writing 1 to a bit at address 5 sets that flag, whatever the fill level.
- R11: If hardware sets a flag in the same cycle that software clears it, the flag stays set.
- R12: `irq` is high exactly when some flag is set and its bit in the enable register (address 6, bits 1:0, readable) is 1. With the enable register at 0, `irq` stays low.
- R13: Writing 1 to bit 2 of address 0 empties both FIFOs and clears both flags in that cycle. The config and enable registers keep their values.
- R14: A `rx_push` while the receive FIFO is full is dropped, and the FIFO contents are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 3 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 8 | Registered read data |
| rx_push | input | 1 | Engine delivers a received byte |
| rx_byte | input | 8 | Received byte |
| rx_full | output | 1 | Receive FIFO cannot take more |
| tx_pop | input | 1 | Engine takes the head transmit byte |
| tx_byte | output | 8 | Head of the transmit FIFO |
| tx_valid | output | 1 | Transmit FIFO non-empty |
| irq | output | 1 | Combined interrupt |

## Verification
A wrong pointer or count shows up at the ports within one access. A read of the data address returns a byte out of order, or a status bit disagrees with the number of bytes pushed so far. The bench therefore sweeps every threshold code against every fill level from 0 to 16 and checks the status word after each push.

A flag register that misses a set, loses a latch or lets a clear beat a hardware set shows at `irq` and in the flag readback one cycle after the offending write. Each of these orderings is driven as its own step.

// File: rtl/serq_pkg.sv
package serq_pkg;
   // register addresses
   localparam logic [2:0] A_CTRL  = 3'd0;
   localparam logic [2:0] A_DATA  = 3'd1;
   localparam logic [2:0] A_FSTAT = 3'd2;
   localparam logic [2:0] A_FCFG  = 3'd3;
   localparam logic [2:0] A_FCLR  = 3'd4;
   localparam logic [2:0] A_FSET  = 3'd5;
   localparam logic [2:0] A_FEN   = 3'd6;
   localparam logic [2:0] A_FLAG  = 3'd7;

   // bit positions
   localparam int CTRL_FLUSH  = 2;
   localparam int ST_RX_EMPTY = 2;
   localparam int ST_RX_HOT   = 3;
   localparam int ST_TX_FULL  = 4;
   localparam int ST_TX_LOW   = 7;
   localparam int CFG_RX_MODE = 3;
   localparam int CFG_TX_MODE = 7;
   localparam logic [7:0] CFG_KEEP = 8'h8F;

   // interrupt sources
   localparam int SRC_TX = 0;
   localparam int SRC_RX = 1;
   localparam int NSRC   = 2;
endpackage

// File: rtl/serq_fifo.sv
module serq_fifo #(
   parameter int DEPTH = 16,
   parameter int DW    = 8,
   localparam int PW   = $clog2(DEPTH),
   localparam int CW   = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          flush,
   input  logic          single,
   input  logic          push,
   input  logic [DW-1:0] wdata,
   input  logic          pop,
   output logic [DW-1:0] head,
   output logic [CW-1:0] count,
   output logic          empty,
   output logic          full
);
   localparam logic [CW-1:0] CAP = CW'(DEPTH);

   logic [DW-1:0] mem [DEPTH];
   logic [PW-1:0] wp, rp;
   logic          do_push, do_pop;

   assign empty   = (count == '0);
   assign full    = single ? !empty : (count == CAP);
   assign do_push = push && !full;
   assign do_pop  = pop && !empty;
   assign head    = mem[rp];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp    <= '0;
         rp    <= '0;
         count <= '0;
      end else if (flush) begin
         wp    <= '0;
         rp    <= '0;
         count <= '0;
      end else begin
         if (do_push) wp <= wp + 1'b1;
         if (do_pop)  rp <= rp + 1'b1;
         case ({do_push, do_pop})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (do_push && !flush) mem[wp] <= wdata;
   end
endmodule

// File: rtl/serq_level.sv
module serq_level #(
   parameter int DEPTH = 16,
   localparam int CW   = $clog2(DEPTH + 1)
) (
   input  logic [2:0]    code,
   input  logic          rx_mode,
   input  logic          tx_mode,
   input  logic [CW-1:0] rx_cnt,
   input  logic [CW-1:0] tx_cnt,
   output logic          rx_hot,
   output logic          tx_low
);
   localparam logic [CW-1:0] HALF = CW'(DEPTH / 2);
   localparam logic [CW-1:0] TOP  = CW'(DEPTH - 1);
   localparam logic [CW-1:0] MAXC = CW'(DEPTH / 2 - 1);

   logic [CW-1:0] code_w, code_sat, lvl;

   always_comb begin
      code_w   = CW'(code);
      code_sat = (code_w > MAXC) ? MAXC : code_w;
      lvl      = TOP - code_sat;
      rx_hot   = rx_mode ? (rx_cnt > lvl) : (rx_cnt != '0);
      tx_low   = tx_mode ? (tx_cnt < HALF) : (tx_cnt == '0);
   end
endmodule

// File: rtl/serq_flags.sv
module serq_flags #(
   parameter int N = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         flush,
   input  logic [N-1:0] hw_set,
   input  logic [N-1:0] sw_set,
   input  logic [N-1:0] sw_clr,
   input  logic [N-1:0] en,
   output logic [N-1:0] flag,
   output logic         irq
);
   for (genvar i = 0; i < N; i++) begin : g_src
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                      flag[i] <= 1'b0;
         else if (flush)                  flag[i] <= 1'b0;
         else if (hw_set[i] || sw_set[i]) flag[i] <= 1'b1;
         else if (sw_clr[i])              flag[i] <= 1'b0;
      end
   end

   assign irq = |(flag & en);
endmodule

// File: rtl/serq_front.sv
module serq_front #(
   parameter int DEPTH = 16,
   parameter int DW    = 8,
   localparam int CW   = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [2:0]    bus_addr,
   input  logic          bus_wr,
   input  logic [DW-1:0] bus_wdata,
   input  logic          bus_rd,
   output logic [DW-1:0] bus_rdata,
   input  logic          rx_push,
   input  logic [DW-1:0] rx_byte,
   output logic          rx_full,
   input  logic          tx_pop,
   output logic [DW-1:0] tx_byte,
   output logic          tx_valid,
   output logic          irq
);
   import serq_pkg::*;

   initial begin : elab_chk
      assert (DW == 8)
         else $error("serq_front: register width must be 8");
      assert (DEPTH >= 4 && DEPTH <= 16 && (DEPTH & (DEPTH - 1)) == 0)
         else $error("serq_front: DEPTH must be a power of two in 4..16");
   end

   logic          flush, data_wr, data_rd;
   logic [DW-1:0] cfg_q, rx_last, rd_mux, status;
   logic [NSRC-1:0] en_q, flag_q, sw_set, sw_clr, hw_set;
   logic [CW-1:0] rx_cnt, tx_cnt;
   logic [DW-1:0] rx_head;
   logic          rx_empty, tx_empty, tx_full, rx_hot, tx_low;

   assign flush   = bus_wr && (bus_addr == A_CTRL) && bus_wdata[CTRL_FLUSH];
   assign data_wr = bus_wr && (bus_addr == A_DATA);
   assign data_rd = bus_rd && (bus_addr == A_DATA);
   assign sw_set  = (bus_wr && bus_addr == A_FSET) ? bus_wdata[NSRC-1:0] : '0;
   assign sw_clr  = (bus_wr && bus_addr == A_FCLR) ? bus_wdata[NSRC-1:0] : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q <= '0;
         en_q  <= '0;
      end else if (bus_wr) begin
         if (bus_addr == A_FCFG) cfg_q <= bus_wdata & CFG_KEEP;
         if (bus_addr == A_FEN)  en_q  <= bus_wdata[NSRC-1:0];
      end
   end

   serq_fifo #(.DEPTH(DEPTH), .DW(DW)) u_rxq (
      .clk   (clk),
      .rst_n (rst_n),
      .flush (flush),
      .single(!cfg_q[CFG_RX_MODE]),
      .push  (rx_push),
      .wdata (rx_byte),
      .pop   (data_rd),
      .head  (rx_head),
      .count (rx_cnt),
      .empty (rx_empty),
      .full  (rx_full)
   );

   serq_fifo #(.DEPTH(DEPTH), .DW(DW)) u_txq (
      .clk   (clk),
      .rst_n (rst_n),
      .flush (flush),
      .single(!cfg_q[CFG_TX_MODE]),
      .push  (data_wr),
      .wdata (bus_wdata),
      .pop   (tx_pop),
      .head  (tx_byte),
      .count (tx_cnt),
      .empty (tx_empty),
      .full  (tx_full)
   );

   assign tx_valid = !tx_empty;

   serq_level #(.DEPTH(DEPTH)) u_lvl (
      .code   (cfg_q[2:0]),
      .rx_mode(cfg_q[CFG_RX_MODE]),
      .tx_mode(cfg_q[CFG_TX_MODE]),
      .rx_cnt (rx_cnt),
      .tx_cnt (tx_cnt),
      .rx_hot (rx_hot),
      .tx_low (tx_low)
   );

   always_comb begin
      hw_set         = '0;
      hw_set[SRC_TX] = tx_low;
      hw_set[SRC_RX] = rx_hot;
   end

   serq_flags #(.N(NSRC)) u_flg (
      .clk   (clk),
      .rst_n (rst_n),
      .flush (flush),
      .hw_set(hw_set),
      .sw_set(sw_set),
      .sw_clr(sw_clr),
      .en    (en_q),
      .flag  (flag_q),
      .irq   (irq)
   );

   // last byte handed to the bus, returned again on an empty read
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    rx_last <= '0;
      else if (data_rd && !rx_empty) rx_last <= rx_head;
   end

   always_comb begin
      status              = '0;
      status[ST_RX_EMPTY] = rx_empty;
      status[ST_RX_HOT]   = rx_hot;
      status[ST_TX_FULL]  = tx_full;
      status[ST_TX_LOW]   = tx_low;
   end

   always_comb begin
      case (bus_addr)
         A_DATA:  rd_mux = rx_empty ? rx_last : rx_head;
         A_FSTAT: rd_mux = status;
         A_FCFG:  rd_mux = cfg_q;
         A_FEN:   rd_mux = DW'(en_q);
         A_FLAG:  rd_mux = DW'(flag_q);
         default: rd_mux = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      bus_rdata <= '0;
      else if (bus_rd) bus_rdata <= rd_mux;
   end
endmodule

// File: rtl/serq_front_chk.sv
module serq_front_chk #(
   parameter int DEPTH = 16,
   localparam int CW   = $clog2(DEPTH + 1)
) (
   input logic          clk,
   input logic          rst_n,
   input logic [2:0]    bus_addr,
   input logic          bus_wr,
   input logic [7:0]    bus_wdata,
   input logic          bus_rd,
   input logic          rx_push,
   input logic          rx_full,
   input logic          irq,
   input logic          rx_hot,
   input logic [1:0]    flag_q,
   input logic [1:0]    en_q,
   input logic [CW-1:0] rx_cnt,
   input logic [CW-1:0] tx_cnt
);
   import serq_pkg::*;

   logic flush_w, clr_rx, set_rx, pop_w;
   assign flush_w = bus_wr && bus_addr == A_CTRL && bus_wdata[CTRL_FLUSH];
   assign clr_rx  = bus_wr && bus_addr == A_FCLR && bus_wdata[SRC_RX];
   assign set_rx  = bus_wr && bus_addr == A_FSET && bus_wdata[SRC_RX];
   assign pop_w   = bus_rd && bus_addr == A_DATA;

   AST_TX_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      tx_cnt <= CW'(DEPTH)); // R3

   AST_RX_DROP_FULL: assert property (@(posedge clk) disable iff (!rst_n)
      rx_full && rx_push && !pop_w && !flush_w |=> rx_cnt == $past(rx_cnt)); // R14

   AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
      flush_w |=> rx_cnt == '0 && tx_cnt == '0); // R13

   AST_FORCE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      set_rx |=> flag_q[SRC_RX]); // R10

   AST_FLAG_LATCHED: assert property (@(posedge clk) disable iff (!rst_n)
      flag_q[SRC_RX] && !clr_rx && !flush_w |=> flag_q[SRC_RX]); // R9

   AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
      clr_rx && !rx_hot |=> !flag_q[SRC_RX]); // R9

   AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      clr_rx && rx_hot |=> flag_q[SRC_RX]); // R11

   AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
      en_q == '0 |-> !irq); // R12
endmodule

bind serq_front serq_front_chk #(.DEPTH(DEPTH)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .bus_addr (bus_addr),
   .bus_wr   (bus_wr),
   .bus_wdata(bus_wdata),
   .bus_rd   (bus_rd),
   .rx_push  (rx_push),
   .rx_full  (rx_full),
   .irq      (irq),
   .rx_hot   (rx_hot),
   .flag_q   (flag_q),
   .en_q     (en_q),
   .rx_cnt   (rx_cnt),
   .tx_cnt   (tx_cnt)
);

// File: tb/serq_front_test.sv
`timescale 1ns/1ps
module serq_front_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [2:0] bus_addr = '0;
   logic       bus_wr = 1'b0;
   logic [7:0] bus_wdata = '0;
   logic       bus_rd = 1'b0;
   logic [7:0] bus_rdata;
   logic       rx_push = 1'b0;
   logic [7:0] rx_byte = '0;
   logic       rx_full;
   logic       tx_pop = 1'b0;
   logic [7:0] tx_byte;
   logic       tx_valid;
   logic       irq;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   serq_front uut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
      .rx_push(rx_push), .rx_byte(rx_byte), .rx_full(rx_full),
      .tx_pop(tx_pop), .tx_byte(tx_byte), .tx_valid(tx_valid), .irq(irq)
   );

   task automatic check(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [7:0] d);
      @(negedge clk);
      bus_addr = a; bus_rd = 1'b1;
      @(negedge clk);
      bus_rd = 1'b0;
      d = bus_rdata;
   endtask

   task automatic rx_in(input logic [7:0] d);
      @(negedge clk);
      rx_byte = d; rx_push = 1'b1;
      @(negedge clk);
      rx_push = 1'b0;
   endtask

   task automatic tx_out();
      @(negedge clk);
      tx_pop = 1'b1;
      @(negedge clk);
      tx_pop = 1'b0;
   endtask

   function automatic int stat(input int rx_n, input int tx_n, input int code,
                               input bit rxm, input bit txm);
      int lvl, s;
      lvl = 15 - code;
      s = 0;
      if (rx_n == 0) s |= 8'h04;
      if (rxm ? (rx_n > lvl) : (rx_n != 0)) s |= 8'h08;
      if (txm ? (tx_n == 16) : (tx_n != 0)) s |= 8'h10;
      if (txm ? (tx_n < 8) : (tx_n == 0)) s |= 8'h80;
      return s;
   endfunction

   localparam logic [2:0] CTRL = 3'd0, DATA = 3'd1, FSTAT = 3'd2, FCFG = 3'd3,
                          FCLR = 3'd4, FSET = 3'd5, FEN = 3'd6, FLAG = 3'd7;

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog expired");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin : main
      logic [7:0] d;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // reset state
      check("R1 rdata", int'(bus_rdata), 0);
      check("R1 irq", int'(irq), 0);
      check("R1 tx_valid", int'(tx_valid), 0);
      check("R1 rx_full", int'(rx_full), 0);
      rd(FSTAT, d); check("R1 status", int'(d), 8'h84);
      rd(FCFG, d);  check("R1 config", int'(d), 0);
      rd(FEN, d);   check("R1 enable", int'(d), 0);
      rd(FLAG, d);  check("R9 tx flag from low fill", int'(d), 8'h01);

      // receive sweep over every threshold code and fill level
      for (int code = 0; code < 8; code++) begin
         wr(FCFG, 8'h88 | 8'(code));
         wr(CTRL, 8'h04);
         for (int n = 1; n <= 16; n++) begin
            rx_in(8'((code << 4) | (n - 1)));
            rd(FSTAT, d);
            check($sformatf("R7 R6 status code %0d fill %0d", code, n),
                  int'(d), stat(n, 0, code, 1'b1, 1'b1));
            check("R8 rx_full", int'(rx_full), int'(n == 16));
         end
         rx_in(8'hEE);
         rd(FSTAT, d);
         check("R14 status after dropped push", int'(d), stat(16, 0, code, 1'b1, 1'b1));
         for (int i = 0; i < 16; i++) begin
            rd(DATA, d);
            check("R4 rx order", int'(d), (code << 4) | i);
         end
         rd(DATA, d);
         check("R5 empty read repeats last", int'(d), (code << 4) | 15);
         rd(FSTAT, d);
         check("R5 still empty", int'(d), 8'h84);
         rx_in(8'h5A);
         rd(DATA, d);
         check("R5 next byte after empty read", int'(d), 8'h5A);
      end

      // transmit FIFO mode
      wr(FCFG, 8'h88);
      wr(CTRL, 8'h04);
      for (int n = 1; n <= 17; n++) begin
         wr(DATA, 8'(8'hA0 + n - 1));
         rd(FSTAT, d);
         check($sformatf("R6 R2 tx status fill %0d", n), int'(d),
               stat(0, (n > 16) ? 16 : n, 0, 1'b1, 1'b1));
      end
      for (int i = 0; i < 16; i++) begin
         check("R2 tx_valid", int'(tx_valid), 1);
         check("R2 tx order", int'(tx_byte), 8'hA0 + i);
         tx_out();
      end
      check("R3 dropped byte never sent", int'(tx_valid), 0);

      // single-byte mode on both sides
      wr(FCFG, 8'h00);
      wr(CTRL, 8'h04);
      rx_in(8'h11);
      check("R8 rx single full", int'(rx_full), 1);
      rx_in(8'h22);
      rd(FSTAT, d); check("R8 R7 single status", int'(d), 8'h88);
      rd(DATA, d);  check("R14 single keeps first", int'(d), 8'h11);
      rd(DATA, d);  check("R5 single empty repeat", int'(d), 8'h11);
      wr(DATA, 8'h33);
      wr(DATA, 8'h44);
      rd(FSTAT, d); check("R8 tx single status", int'(d), 8'h14);
      check("R8 tx single head", int'(tx_byte), 8'h33);
      tx_out();
      check("R3 tx single drop", int'(tx_valid), 0);

      // config mask
      wr(FCFG, 8'hFF);
      rd(FCFG, d); check("R8 config stored bits", int'(d), 8'h8F);

      // interrupt flags
      wr(CTRL, 8'h04);
      wr(FEN, 8'h03);
      rd(FEN, d);  check("R12 enable readback", int'(d), 8'h03);
      rd(FLAG, d); check("R9 tx flag", int'(d), 8'h01);
      check("R12 irq on", int'(irq), 1);
      wr(FCLR, 8'h01);
      rd(FLAG, d); check("R11 hw set beats clear tx", int'(d), 8'h01);
      wr(FEN, 8'h02);
      check("R12 irq masked", int'(irq), 0);
      rx_in(8'h01);
      rd(FLAG, d); check("R7 one byte below threshold", int'(d), 8'h01);
      wr(FSET, 8'h02);
      rd(FLAG, d); check("R10 forced rx flag", int'(d), 8'h03);
      check("R12 irq from forced rx", int'(irq), 1);
      wr(FCLR, 8'h02);
      rd(FLAG, d); check("R9 clear rx flag", int'(d), 8'h01);
      check("R12 irq off after clear", int'(irq), 0);
      for (int i = 2; i <= 9; i++) rx_in(8'(i));
      rd(FLAG, d); check("R9 R7 rx flag above 8", int'(d), 8'h03);
      wr(FCLR, 8'h02);
      rd(FLAG, d); check("R11 hw set beats clear rx", int'(d), 8'h03);
      for (int i = 1; i <= 9; i++) begin
         rd(DATA, d);
         check("R4 drain order", int'(d), i);
      end
      rd(FLAG, d); check("R9 rx flag latched after drain", int'(d), 8'h03);
      wr(FCLR, 8'h02);
      rd(FLAG, d); check("R9 rx flag cleared", int'(d), 8'h01);
      wr(FEN, 8'h00);
      wr(FSET, 8'h03);
      check("R12 no irq with mask zero", int'(irq), 0);

      // flush keeps config and mask
      for (int i = 0; i < 3; i++) rx_in(8'(8'h70 + i));
      for (int i = 0; i < 5; i++) wr(DATA, 8'(8'h90 + i));
      wr(CTRL, 8'h04);
      rd(FSTAT, d); check("R13 status after flush", int'(d), 8'h84);
      rd(FLAG, d);  check("R13 flags after flush", int'(d), 8'h01);
      check("R13 tx empty", int'(tx_valid), 0);
      rd(FCFG, d);  check("R13 config kept", int'(d), 8'h8F);
      rd(FEN, d);   check("R13 enable kept", int'(d), 8'h00);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule